// File: doc/BRIEF.md
# Ethernet MAC transmit status tracker

This block sits next to a half-duplex Ethernet transmit engine. It gathers the engine's per-packet event strobes into one 32-bit status word that software can read. The engine reports these events: collisions, carrier sense, transmit FIFO empty, FIFO parity errors, received pause frames, deferral, and the end of each packet. The block keeps the collision count for the current packet. From a bit-time tick it works out two timing flags: late collisions and maximum deferral. A transmit FIFO parity error can shut off the transmitter.

A companion control word holds the transmit enable, the halt-immediate control and one interrupt enable per status flag. The interrupt output stays high while any enabled flag is set. Software clears a flag by writing a one to its bit position. The bit-time tick comes at the fast line rate. When the slow speed is selected, one bit time is counted every `SLOW_DIV` ticks.

Top module: `tx_status_tracker`

## Requirements
- R1: After reset the status word, the control word and `irq` are all zero, and status bits 31:16 always read as zero.
- R2: A collision taken while `tx_active` is high adds one to the count in status bits 3:0. A `pkt_start` pulse clears bits 4:0 and wins over a collision in the same cycle.
- R3: The 16th collision of one packet sets bit 4 (excessive), returns the count to 0 and sets bit 14 (completion). Further collisions are ignored until the next `pkt_start`. Whenever bit 4 is set, the count is zero.
- R4: A collision sets bit 12 (late) once at least `LATE_BITS` bit times have passed since `tx_active` went high. A collision one bit time earlier does not set it.
- R5: With `speed_100` high, every `bit_tick` is one bit time. With `speed_100` low, only every `SLOW_DIV`-th `bit_tick` counts. A free prescaler, cleared at reset, counts every tick.
- R6: While `deferring` is high, bit 5 is set. After `deferring` has stayed high for `DEFER_BITS` bit times, bit 9 (deferral limit) is set on the following clock edge.
- R7: `fifo_perr` sets bit 13. If control bit 13 is set, it also clears control bit 0 (transmit enable), and this overrides a control write in the same cycle.
- R8: Bit 8 (underrun) is set by `fifo_empty` only while `tx_active` is high. Bit 6 is set by `pause_rx`, and bit 11 by `sqe_miss`.
- R9: `pkt_done` sets bit 14. It sets bit 7 if `done_irq` is high. It sets bit 10 (no carrier) if `carrier` was never high together with `tx_active` since the last `pkt_start`.
- R10: Bit 15 (halted) is set when control bit 0 goes from 1 to 0, or control bit 1 (halt immediately) goes from 0 to 1.
- R11: Writing status clears each of bits 15:4 where the data bit is 1. An event in the same cycle wins over the clear. Writes to bits 3:0 have no effect.
- R12: `irq` is high exactly when some status bit in 15:4 is set together with the control bit in the same position.
- R13: A control write stores data bits 15:4, 1 and 0. Control bits 3:2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per fast-rate bit time |
| speed_100 | input | 1 | 1 = fast rate, 0 = slow rate |
| pkt_start | input | 1 | A new packet begins |
| tx_active | input | 1 | Bits of the current attempt are on the wire |
| coll | input | 1 | Collision strobe |
| carrier | input | 1 | Carrier sense level |
| fifo_empty | input | 1 | Transmit FIFO empty |
| fifo_perr | input | 1 | Transmit FIFO parity error strobe |
| pause_rx | input | 1 | Pause frame delayed the transmission |
| deferring | input | 1 | Transmitter is deferring |
| sqe_miss | input | 1 | SQE test signal missing |
| pkt_done | input | 1 | Packet transmitted or discarded |
| done_irq | input | 1 | Packet asks for an interrupt on completion |
| wr_stat | input | 1 | Write-one-to-clear strobe for status |
| wr_ctl | input | 1 | Write strobe for control |
| wr_data | input | 16 | Write data |
| stat_q | output | 32 | Status word |
| ctl_q | output | 16 | Control word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the excessive-collision abort. It needs sixteen collisions on one packet, and none of them may fall past the late boundary. The stimulus therefore lowers `tx_active` between retries, so that each attempt restarts its bit-time count. It then checks the count at fifteen, the wrap to zero at sixteen, and that a seventeenth strobe is ignored. The late and deferral boundaries are reached by holding `tx_active` or `deferring` for an exact number of edges with a tick on every cycle. At the slow speed the prescaler phase is not known, so the check uses margins instead of an exact count.

// File: rtl/tx_status_tracker.sv
module tx_status_tracker #(
  parameter int LATE_BITS  = 512,
  parameter int DEFER_BITS = 32768,
  parameter int SLOW_DIV   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        speed_100,
  input  logic        pkt_start,
  input  logic        tx_active,
  input  logic        coll,
  input  logic        carrier,
  input  logic        fifo_empty,
  input  logic        fifo_perr,
  input  logic        pause_rx,
  input  logic        deferring,
  input  logic        sqe_miss,
  input  logic        pkt_done,
  input  logic        done_irq,
  input  logic        wr_stat,
  input  logic        wr_ctl,
  input  logic [15:0] wr_data,
  output logic [31:0] stat_q,
  output logic [15:0] ctl_q,
  output logic        irq
);
  localparam int LW = $clog2(LATE_BITS + 1);
  localparam int DW = $clog2(DEFER_BITS + 1);
  localparam int PW = $clog2(SLOW_DIV);
  localparam logic [15:0] CTL_MASK = 16'hFFF3;

  logic [PW-1:0] pre_q;
  logic [LW-1:0] bits_q;
  logic [DW-1:0] def_q;
  logic [3:0]    cnt_q;
  logic          abort_q, carr_q;
  logic [15:4]   flg_q, set_v, clr_v;
  logic [15:0]   ctl_nxt;

  wire bit_stb  = bit_tick & (speed_100 | (pre_q == PW'(SLOW_DIV - 1)));
  wire late_now = bits_q == LW'(LATE_BITS);
  wire def_max  = def_q == DW'(DEFER_BITS);
  wire coll_ok  = coll & tx_active & ~abort_q & ~pkt_start;
  wire wrap16   = coll_ok & (cnt_q == 4'hF);

  always_comb begin
    ctl_nxt = wr_ctl ? (wr_data & CTL_MASK) : ctl_q;
    if (fifo_perr && ctl_q[13]) ctl_nxt[0] = 1'b0;
  end

  wire halt_evt = (ctl_q[0] & ~ctl_nxt[0]) | (~ctl_q[1] & ctl_nxt[1]);

  always_comb begin
    set_v      = '0;
    set_v[4]   = wrap16;
    set_v[5]   = deferring;
    set_v[6]   = pause_rx;
    set_v[7]   = pkt_done & done_irq;
    set_v[8]   = fifo_empty & tx_active;
    set_v[9]   = deferring & def_max;
    set_v[10]  = pkt_done & ~carr_q;
    set_v[11]  = sqe_miss;
    set_v[12]  = coll_ok & late_now;
    set_v[13]  = fifo_perr;
    set_v[14]  = pkt_done | wrap16;
    set_v[15]  = halt_evt;
  end

  assign clr_v = ({12{wr_stat}} & wr_data[15:4]) | {11'b0, pkt_start};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      bits_q  <= '0;
      def_q   <= '0;
    end else begin
      if (bit_tick) pre_q <= (pre_q == PW'(SLOW_DIV - 1)) ? '0 : pre_q + 1'b1;
      if (!tx_active) bits_q <= '0;
      else if (bit_stb && !late_now) bits_q <= bits_q + 1'b1;
      if (!deferring) def_q <= '0;
      else if (bit_stb && !def_max) def_q <= def_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      abort_q <= 1'b0;
      carr_q  <= 1'b0;
    end else if (pkt_start) begin
      cnt_q   <= '0;
      abort_q <= 1'b0;
      carr_q  <= 1'b0;
    end else begin
      if (coll_ok) cnt_q <= wrap16 ? 4'h0 : cnt_q + 1'b1;
      if (wrap16) abort_q <= 1'b1;
      if (carrier && tx_active) carr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '0;
      ctl_q <= '0;
    end else begin
      flg_q <= (flg_q & ~clr_v) | set_v;
      ctl_q <= ctl_nxt;
    end
  end

  assign stat_q = {16'b0, flg_q, cnt_q};
  assign irq    = |(flg_q & ctl_q[15:4]);
endmodule

// File: rtl/tx_status_tracker_chk.sv
module tx_status_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_start,
  input logic        pkt_done,
  input logic        fifo_perr,
  input logic [31:0] stat_q,
  input logic [15:0] ctl_q,
  input logic        irq
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> stat_q[4:0] == 5'd0);
  p_excess_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[4] |-> stat_q[3:0] == 4'd0);
  p_parity_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_perr && ctl_q[13]) |=> !ctl_q[0]);
  p_done_sets_comp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> stat_q[14]);
  p_halt_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[0]) |-> stat_q[15]);
  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q[15:4] != 12'd0));
endmodule

bind tx_status_tracker tx_status_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_done(pkt_done),
  .fifo_perr(fifo_perr), .stat_q(stat_q), .ctl_q(ctl_q), .irq(irq)
);

// File: tb/tb_tx_status_tracker.sv
module tb_tx_status_tracker;
  localparam int LATE = 20;
  localparam int DEFER = 40;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b1, speed_100 = 1'b1, pkt_start = 1'b0, tx_active = 1'b0;
  logic coll = 1'b0, carrier = 1'b0, fifo_empty = 1'b0, fifo_perr = 1'b0;
  logic pause_rx = 1'b0, deferring = 1'b0, sqe_miss = 1'b0, pkt_done = 1'b0;
  logic done_irq = 1'b0, wr_stat = 1'b0, wr_ctl = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] stat_q;
  logic [15:0] ctl_q;
  logic irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_status_tracker #(.LATE_BITS(LATE), .DEFER_BITS(DEFER), .SLOW_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_100(speed_100),
    .pkt_start(pkt_start), .tx_active(tx_active), .coll(coll), .carrier(carrier),
    .fifo_empty(fifo_empty), .fifo_perr(fifo_perr), .pause_rx(pause_rx),
    .deferring(deferring), .sqe_miss(sqe_miss), .pkt_done(pkt_done),
    .done_irq(done_irq), .wr_stat(wr_stat), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .stat_q(stat_q), .ctl_q(ctl_q), .irq(irq)
  );

  // behavioural reference
  logic [15:0] m_st, m_ctl, s, nctl;
  bit m_abort, m_carr, stb, cok, wrap;
  int m_pre, m_bits, m_def;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ctl = 0; m_abort = 0; m_carr = 0;
      m_pre = 0; m_bits = 0; m_def = 0;
    end else begin
      stb  = bit_tick && (speed_100 || m_pre == DIV - 1);
      cok  = coll && tx_active && !m_abort && !pkt_start;
      wrap = cok && (m_st[3:0] == 4'd15);
      nctl = wr_ctl ? (wr_data & 16'hFFF3) : m_ctl;
      if (fifo_perr && m_ctl[13]) nctl[0] = 1'b0;
      s = m_st;
      if (wr_stat) s[15:4] = s[15:4] & ~wr_data[15:4];
      if (pkt_start) s[4:0] = 5'd0;
      if (cok) s[3:0] = wrap ? 4'd0 : s[3:0] + 4'd1;
      if (wrap) begin s[4] = 1'b1; s[14] = 1'b1; end
      if (cok && m_bits >= LATE) s[12] = 1'b1;
      if (deferring) s[5] = 1'b1;
      if (deferring && m_def >= DEFER) s[9] = 1'b1;
      if (pause_rx) s[6] = 1'b1;
      if (pkt_done) begin
        s[14] = 1'b1;
        if (done_irq) s[7] = 1'b1;
        if (!m_carr) s[10] = 1'b1;
      end
      if (fifo_empty && tx_active) s[8] = 1'b1;
      if (sqe_miss) s[11] = 1'b1;
      if (fifo_perr) s[13] = 1'b1;
      if ((m_ctl[0] && !nctl[0]) || (!m_ctl[1] && nctl[1])) s[15] = 1'b1;
      if (pkt_start) begin m_abort = 0; m_carr = 0; end
      else begin
        if (wrap) m_abort = 1;
        if (carrier && tx_active) m_carr = 1;
      end
      if (!tx_active) m_bits = 0; else if (stb && m_bits < LATE) m_bits++;
      if (!deferring) m_def = 0; else if (stb && m_def < DEFER) m_def++;
      if (bit_tick) m_pre = (m_pre + 1) % DIV;
      m_st = s; m_ctl = nctl;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (stat_q !== {16'b0, m_st} || ctl_q !== m_ctl ||
          irq !== |(m_st[15:4] & m_ctl[15:4])) begin
        bad++;
        $display("FAIL model R11 stat=%h/%h ctl=%h/%h irq=%b", stat_q, m_st, ctl_q, m_ctl, irq);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wst(input logic [15:0] d);
    wr_stat = 1'b1; wr_data = d; tick(1); wr_stat = 1'b0;
  endtask

  task automatic wctl(input logic [15:0] d);
    wr_ctl = 1'b1; wr_data = d; tick(1); wr_ctl = 1'b0;
  endtask

  task automatic hit();
    coll = 1'b1; tick(1); coll = 1'b0;
  endtask

  task automatic pstart();
    pkt_start = 1'b1; tick(1); pkt_start = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 stat", stat_q, 0);
    chk("R1 ctl", {16'b0, ctl_q}, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    wctl(16'hFFFF);
    chk("R13 ctl mask", {16'b0, ctl_q}, 32'h0000FFF3);
    chk("R10 halt imm rise", {31'b0, stat_q[15]}, 1);
    chk("R12 irq on", {31'b0, irq}, 1);
    wctl(16'h0001);
    wst(16'hFFFF);
    chk("R11 w1c all", stat_q, 0);
    chk("R12 irq off", {31'b0, irq}, 0);

    pstart();
    tx_active = 1'b1; carrier = 1'b1;
    repeat (3) begin hit(); tick(1); end
    chk("R2 count3", {28'b0, stat_q[3:0]}, 3);
    chk("R4 early not late", {31'b0, stat_q[12]}, 0);
    fifo_empty = 1'b1; tick(1); fifo_empty = 1'b0;
    chk("R8 underrun", {31'b0, stat_q[8]}, 1);
    done_irq = 1'b1; pkt_done = 1'b1; tick(1); pkt_done = 1'b0; done_irq = 1'b0;
    chk("R9 comp/inttx/ncarr", {29'b0, stat_q[14], stat_q[7], stat_q[10]}, 3'b110);
    tx_active = 1'b0;
    wst(16'hFFFF);
    fifo_empty = 1'b1; tick(1); fifo_empty = 1'b0;
    chk("R8 idle empty ignored", {31'b0, stat_q[8]}, 0);

    pstart();
    chk("R2 start clears", {27'b0, stat_q[4:0]}, 0);
    for (int i = 0; i < 15; i++) begin
      tx_active = 1'b1; tick(1); hit(); tx_active = 1'b0; tick(1);
    end
    chk("R2 count15", {27'b0, stat_q[4:0]}, 32'h0F);
    tx_active = 1'b1; tick(1); hit(); tx_active = 1'b0; tick(1);
    chk("R3 excessive", {27'b0, stat_q[4:0]}, 32'h10);
    chk("R3 abort completes", {31'b0, stat_q[14]}, 1);
    tx_active = 1'b1; tick(1); hit(); tx_active = 1'b0; tick(1);
    chk("R3 ignored after abort", {27'b0, stat_q[4:0]}, 32'h10);

    pstart();
    tx_active = 1'b1; tick(19); hit();
    chk("R4 boundary-1", {31'b0, stat_q[12]}, 0);
    chk("R2 count1", {28'b0, stat_q[3:0]}, 1);
    tx_active = 1'b0; tick(1); tx_active = 1'b1; tick(20); hit();
    chk("R4 boundary", {31'b0, stat_q[12]}, 1);
    tx_active = 1'b0; tick(1);
    wst(16'hFFFF);
    speed_100 = 1'b0;
    tx_active = 1'b1; tick(20); hit();
    chk("R5 slow not late", {31'b0, stat_q[12]}, 0);
    tx_active = 1'b0; tick(1); tx_active = 1'b1; tick(90); hit();
    chk("R5 slow late", {31'b0, stat_q[12]}, 1);
    tx_active = 1'b0; speed_100 = 1'b1; tick(1);

    wst(16'hFFFF);
    deferring = 1'b1; tick(40);
    chk("R6 deferred", {31'b0, stat_q[5]}, 1);
    chk("R6 not yet max", {31'b0, stat_q[9]}, 0);
    tick(1);
    chk("R6 max deferral", {31'b0, stat_q[9]}, 1);
    deferring = 1'b0; tick(1);

    wst(16'hFFFF);
    wctl(16'h2001);
    fifo_perr = 1'b1; tick(1); fifo_perr = 1'b0;
    chk("R7 tx_en cleared", {16'b0, ctl_q}, 32'h2000);
    chk("R7 parity flag", {31'b0, stat_q[13]}, 1);
    chk("R10 halted", {31'b0, stat_q[15]}, 1);
    chk("R12 irq parity", {31'b0, irq}, 1);
    wst(16'hFFFF);
    wctl(16'h0001);
    fifo_perr = 1'b1; tick(1); fifo_perr = 1'b0;
    chk("R7 no enable keeps tx", {16'b0, ctl_q}, 32'h0001);
    chk("R10 no halt", {31'b0, stat_q[15]}, 0);
    wctl(16'h2001);
    wr_ctl = 1'b1; wr_data = 16'h2001; fifo_perr = 1'b1; tick(1);
    wr_ctl = 1'b0; fifo_perr = 1'b0;
    chk("R7 beats write", {31'b0, ctl_q[0]}, 0);

    wctl(16'h0001);
    wst(16'hFFFF);
    pstart();
    carrier = 1'b0; tx_active = 1'b1; tick(5);
    pkt_done = 1'b1; tick(1); pkt_done = 1'b0;
    chk("R9 no carrier", {31'b0, stat_q[10]}, 1);
    hit();
    tx_active = 1'b0;
    pause_rx = 1'b1; tick(1); pause_rx = 1'b0;
    sqe_miss = 1'b1; tick(1); sqe_miss = 1'b0;
    chk("R8 pause/sqe", {30'b0, stat_q[11], stat_q[6]}, 2'b11);
    pause_rx = 1'b1; wr_stat = 1'b1; wr_data = 16'h0040; tick(1);
    pause_rx = 1'b0; wr_stat = 1'b0;
    chk("R11 set wins", {31'b0, stat_q[6]}, 1);
    wst(16'h0040);
    chk("R11 cleared", {31'b0, stat_q[6]}, 0);
    wst(16'h000F);
    chk("R11 count ro", {28'b0, stat_q[3:0]}, 1);

    wctl(16'h0041);
    chk("R12 unenabled flags", {31'b0, irq}, 0);
    pause_rx = 1'b1; tick(1); pause_rx = 1'b0;
    chk("R12 enabled flag", {31'b0, irq}, 1);
    wst(16'h0040);
    chk("R12 cleared", {31'b0, irq}, 0);
    chk("R1 upper zero", {16'b0, stat_q[31:16]}, 0);

    tick(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule